// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns the top eight bits of a 20-bit physical memory address (address bits 19 down to 12, one 4 KB page per value) into two active-low chip selects: one for a ROM device and one for a RAM device. Three 8-bit bound registers set the windows. The ROM window always starts at page zero and ends at a programmable top page. The RAM window has a programmable floor page and a programmable ceiling page. Where the two windows overlap, ROM wins.

The bounds are written and read back through a small register port with an index, write data, a write strobe and read data. Both selects are qualified by an active-high memory-request strobe, so they stay high during I/O, refresh and idle bus states. An overlay input forces address bit 18 to one for the ROM comparison only. This pushes low pages out of a small ROM window so that RAM can take over that region. Address bit 18 is expected to be the raw CPU address bit, before any sharing of that pin with a timer output. The decode is purely combinational from the registered bounds and the current page.

Top module: `memsel_decoder`

## Requirements
- R1: After reset, all three bound registers hold 0xFF and read back 0xFF.
- R2: With the memory request high and overlay low, `rom_sel_n` is low exactly when the page is less than or equal to the ROM top bound.
- R3: With the memory request high, `ram_sel_n` is low exactly when the page lies between the RAM floor and the RAM ceiling, both inclusive, and the ROM select is not active.
- R4: The two selects are never low together. For pages inside both windows, the ROM select is low and the RAM select is high.
- R5: While the memory request is low, both selects are high, whatever the page and the bounds.
- R6: With overlay high, the ROM comparison uses the page with its bit 6 (address bit 18) forced to one. The RAM comparison uses the unmodified page.
- R7: Register index 0 is the ROM top, index 1 the RAM floor and index 2 the RAM ceiling. A write takes effect at the next clock edge and reads back unchanged. Index 3 reads as 0x00, and writes to it change no bound.
- R8: When the RAM floor is above the RAM ceiling, the RAM select never asserts.
- R9: With the reset bounds, every page with the memory request high selects ROM and never RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Active-high memory-request strobe qualifying both selects |
| page | input | 8 | Address bits 19..12 of the current access |
| overlay | input | 1 | Forces address bit 18 high for the ROM comparison |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_idx | input | 2 | Bound register index (0 ROM top, 1 RAM floor, 2 RAM ceiling) |
| cfg_wdata | input | 8 | Bound register write data |
| cfg_rdata | output | 8 | Read data of the indexed bound register |
| rom_sel_n | output | 1 | Active-low ROM chip select |
| ram_sel_n | output | 1 | Active-low RAM chip select |

## Verification
The assertions assume that the page, the memory request and the overlay input are settled before the edge where the selects are used, and that register writes happen only outside reset. The stimulus changes inputs just after a rising edge and samples at the falling edge. It sweeps all 256 pages for each bound setting: reset values, disjoint windows, overlapping windows, an inverted RAM window, overlay with two ROM tops, and a request-low pass. Writes to the spare index check that no bound changes.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    localparam int PHYS_AW      = 20;
    localparam int PAGE_LSB     = 12;
    localparam int PAGE_W       = PHYS_AW - PAGE_LSB;
    localparam int OVL_ADDR_BIT = 18;
    localparam int OVL_IDX      = OVL_ADDR_BIT - PAGE_LSB;
    localparam int NUM_BOUNDS   = 3;
    localparam int REG_IDX_W    = 2;

    typedef logic [PAGE_W-1:0] page_t;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_ROM_TOP   = 2'd0,
        IDX_RAM_FLOOR = 2'd1,
        IDX_RAM_CEIL  = 2'd2,
        IDX_SPARE     = 2'd3
    } bound_idx_e;

    typedef struct packed {
        page_t rom_top;
        page_t ram_floor;
        page_t ram_ceil;
    } bounds_t;

    localparam page_t BOUND_RESET = '1;

    // Page as seen by the ROM comparator: bit 18 optionally forced high.
    function automatic page_t rom_view(page_t p, logic force_hi);
        page_t r;
        r = p;
        if (force_hi) r[OVL_IDX] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/memsel_regfile.sv
module memsel_regfile
    import memsel_pkg::*;
#(
    parameter int W     = PAGE_W,
    parameter int N     = NUM_BOUNDS,
    parameter int IDX_W = REG_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [W-1:0]     bound_q [N]
);

    for (genvar g = 0; g < N; g++) begin : g_bound
        always_ff @(posedge clk) begin
            if (rst) begin
                bound_q[g] <= '1;
            end else if (we && idx == IDX_W'(g)) begin
                bound_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == IDX_W'(i)) rdata = bound_q[i];
        end
    end

endmodule

// File: rtl/memsel_window.sv
module memsel_window #(
    parameter int W = 8
) (
    input  logic [W-1:0] page,
    input  logic [W-1:0] floor_pg,
    input  logic [W-1:0] ceil_pg,
    output logic         hit
);

    // Inclusive window; an inverted window (floor above ceiling) never hits.
    assign hit = (page >= floor_pg) && (page <= ceil_pg);

endmodule

// File: rtl/memsel_arbiter.sv
module memsel_arbiter (
    input  logic mem_req,
    input  logic rom_hit,
    input  logic ram_hit,
    output logic rom_sel_n,
    output logic ram_sel_n
);

    logic rom_grant;
    logic ram_grant;

    always_comb begin
        rom_grant = mem_req && rom_hit;
        ram_grant = mem_req && ram_hit && !rom_hit;
    end

    assign rom_sel_n = !rom_grant;
    assign ram_sel_n = !ram_grant;

endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mem_req,
    input  logic [PAGE_W-1:0]    page,
    input  logic                 overlay,
    input  logic                 cfg_we,
    input  logic [REG_IDX_W-1:0] cfg_idx,
    input  logic [PAGE_W-1:0]    cfg_wdata,
    output logic [PAGE_W-1:0]    cfg_rdata,
    output logic                 rom_sel_n,
    output logic                 ram_sel_n
);

    logic [PAGE_W-1:0] bound_q [NUM_BOUNDS];
    bounds_t           bounds;
    page_t             rom_page;
    logic              rom_hit;
    logic              ram_hit;

    memsel_regfile #(
        .W     (PAGE_W),
        .N     (NUM_BOUNDS),
        .IDX_W (REG_IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .bound_q (bound_q)
    );

    always_comb begin
        bounds.rom_top   = bound_q[IDX_ROM_TOP];
        bounds.ram_floor = bound_q[IDX_RAM_FLOOR];
        bounds.ram_ceil  = bound_q[IDX_RAM_CEIL];
        rom_page         = rom_view(page, overlay);
    end

    memsel_window #(.W(PAGE_W)) u_rom_win (
        .page     (rom_page),
        .floor_pg ('0),
        .ceil_pg  (bounds.rom_top),
        .hit      (rom_hit)
    );

    memsel_window #(.W(PAGE_W)) u_ram_win (
        .page     (page),
        .floor_pg (bounds.ram_floor),
        .ceil_pg  (bounds.ram_ceil),
        .hit      (ram_hit)
    );

    memsel_arbiter u_arb (
        .mem_req   (mem_req),
        .rom_hit   (rom_hit),
        .ram_hit   (ram_hit),
        .rom_sel_n (rom_sel_n),
        .ram_sel_n (ram_sel_n)
    );

endmodule

// File: rtl/memsel_checker.sv
module memsel_checker
    import memsel_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 mem_req,
    input logic [PAGE_W-1:0]    page,
    input logic                 overlay,
    input logic                 cfg_we,
    input logic [REG_IDX_W-1:0] cfg_idx,
    input logic [PAGE_W-1:0]    cfg_wdata,
    input logic                 rom_sel_n,
    input logic                 ram_sel_n,
    input bounds_t              bounds
);

    assert_reset_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bounds.rom_top == '1 && bounds.ram_floor == '1 && bounds.ram_ceil == '1));

    assert_rom_window_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !overlay && page <= bounds.rom_top) |-> !rom_sel_n);

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!rom_sel_n && !ram_sel_n));

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> (rom_sel_n && ram_sel_n));

    assert_overlay_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && overlay && (page | 8'h40) > bounds.rom_top) |-> rom_sel_n);

    assert_write_rom_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == 2'd0) |=> bounds.rom_top == $past(cfg_wdata));

    assert_spare_write_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == 2'd3) |=> $stable(bounds));

    assert_inverted_R8: assert property (@(posedge clk) disable iff (rst)
        (bounds.ram_floor > bounds.ram_ceil) |-> ram_sel_n);

endmodule

bind memsel_decoder memsel_checker u_memsel_checker (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .page      (page),
    .overlay   (overlay),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .rom_sel_n (rom_sel_n),
    .ram_sel_n (ram_sel_n),
    .bounds    (bounds)
);

// File: tb/test_memsel_decoder.sv
`timescale 1ns/1ps
module test_memsel_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_req = 1'b0;
    logic [7:0] page = 8'h00;
    logic       overlay = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       rom_sel_n;
    logic       ram_sel_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference state
    int m_rom_top = 255;
    int m_ram_lo  = 255;
    int m_ram_hi  = 255;

    always #2.5 clk = ~clk;

    memsel_decoder i_memsel_decoder (
        .clk(clk), .rst(rst), .mem_req(mem_req), .page(page), .overlay(overlay),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n)
    );

    function automatic bit exp_rom(int p, bit req, bit ovl);
        int v;
        v = ovl ? (p | 64) : p;
        return req && (v <= m_rom_top);
    endfunction

    function automatic bit exp_ram(int p, bit req, bit ovl);
        return req && !exp_rom(p, req, ovl) && (p >= m_ram_lo) && (p <= m_ram_hi);
    endfunction

    task automatic check_val(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic write_bound(int idx, int val);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = 8'(val);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        case (idx)
            0: m_rom_top = val;
            1: m_ram_lo  = val;
            2: m_ram_hi  = val;
            default: ;
        endcase
    endtask

    task automatic read_check(int idx, int exp, string tag);
        @(posedge clk); #1;
        cfg_idx = 2'(idx);
        @(negedge clk);
        check_val(tag, int'(cfg_rdata), exp);
    endtask

    // Compare both selects against the model on every clock of a 256-page sweep.
    task automatic sweep(bit req, bit ovl, string ctx);
        for (int p = 0; p < 256; p++) begin
            bit er, ea;
            string rtag, atag;
            @(posedge clk); #1;
            page = 8'(p); mem_req = req; overlay = ovl;
            @(negedge clk);
            er = exp_rom(p, req, ovl);
            ea = exp_ram(p, req, ovl);
            rtag = !req ? "R5" : (ovl ? "R6" : "R2");
            if (!req) atag = "R5";
            else if (m_ram_lo > m_ram_hi) atag = "R8";
            else if (er && p >= m_ram_lo && p <= m_ram_hi) atag = "R4";
            else atag = "R3";
            check_val({rtag, " rom_sel_n ", ctx}, int'(rom_sel_n), int'(!er));
            check_val({atag, " ram_sel_n ", ctx}, int'(ram_sel_n), int'(!ea));
        end
        @(posedge clk); #1;
        mem_req = 1'b0; overlay = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values read back
        read_check(0, 8'hFF, "R1 rom_top reset");
        read_check(1, 8'hFF, "R1 ram_floor reset");
        read_check(2, 8'hFF, "R1 ram_ceil reset");
        read_check(3, 8'h00, "R7 spare index reads zero");

        // R9: reset bounds, ROM covers everything
        sweep(1'b1, 1'b0, "R9 reset bounds");

        // Disjoint windows
        write_bound(0, 8'h3F);
        write_bound(1, 8'h40);
        write_bound(2, 8'h7F);
        read_check(0, 8'h3F, "R7 rom_top readback");
        read_check(1, 8'h40, "R7 ram_floor readback");
        read_check(2, 8'h7F, "R7 ram_ceil readback");
        sweep(1'b1, 1'b0, "disjoint");

        // R7: spare index write ignored
        write_bound(3, 8'h12);
        read_check(0, 8'h3F, "R7 spare write rom_top");
        read_check(1, 8'h40, "R7 spare write ram_floor");
        read_check(2, 8'h7F, "R7 spare write ram_ceil");
        read_check(3, 8'h00, "R7 spare still zero");

        // R5: request low
        sweep(1'b0, 1'b0, "R5 idle");
        sweep(1'b0, 1'b1, "R5 idle overlay");

        // R4: overlapping windows
        write_bound(0, 8'h50);
        write_bound(1, 8'h40);
        write_bound(2, 8'hBF);
        sweep(1'b1, 1'b0, "R4 overlap");

        // R8: inverted RAM window
        write_bound(1, 8'hC0);
        write_bound(2, 8'h80);
        sweep(1'b1, 1'b0, "R8 inverted");

        // R6: overlay pushes low pages out of a small ROM window
        write_bound(0, 8'h3F);
        write_bound(1, 8'h00);
        write_bound(2, 8'hFF);
        sweep(1'b1, 1'b1, "R6 overlay small rom");
        sweep(1'b1, 1'b0, "R3 full ram no overlay");
        write_bound(0, 8'h7F);
        sweep(1'b1, 1'b1, "R6 overlay rom 7F");

        // R1: reset again restores bounds
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        m_rom_top = 255; m_ram_lo = 255; m_ram_hi = 255;
        read_check(0, 8'hFF, "R1 rom_top re-reset");
        read_check(2, 8'hFF, "R1 ram_ceil re-reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule